// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the slave end of a four-wire serial link that gives a host byte access to a 32K x 8 memory array. The host frames every command by holding chip select low. The block shifts in an 8-bit opcode, MSB first. After the opcode come a 16-bit address and, for the fast read command, one dummy byte. The block then either streams array bytes out on the serial output or takes serial bytes and commits them to the array. In both directions it walks an internal 15-bit address that wraps from the top of the array back to zero.

The serial pins are sampled by a fast system clock through a synchronizer and edge detector, and all control runs in that clock domain. The array itself sits outside the block, on a plain read port and a write-strobe port. Writes need a write-enable latch, which a separate command sets, and it clears itself when the write frame closes. An inclusive protected address window drops write data but still advances the address. A busy input marks a background store or recall cycle and shuts out array access while it is high.

Top module: `spi_mem_slave`

## Requirements
- R1: Opcodes are shifted in MSB first on rising SCK edges (mode 0). The codes are 0x03 read, 0x0B fast read, 0x02 write and 0x06 write enable. Any other opcode makes the block drive nothing and write nothing until chip select goes high.
- R2: The two address bytes arrive MSB first. The top bit of the 16 is ignored, so the array address is the low 15 bits.
- R3: A read puts out bit 7 of the addressed byte on the SCK falling edge right after the last address bit, then the lower bits on the following falling edges. The output enable is low whenever chip select is high or no read data has been driven yet in the frame.
- R4: While chip select stays low, a read moves on to the next address after each byte, and 0x7FFF is followed by 0x0000.
- R5: A fast read takes one dummy byte after the address, and output starts on the falling edge after its last bit. Increment and wrap match R4.
- R6: A write opcode is taken only if the write-enable latch is set. Otherwise the whole frame writes nothing.
- R7: In an accepted write, each complete data byte goes to the current address and the address then advances, with 0x7FFF followed by 0x0000.
- R8: The write-enable latch is cleared when chip select rises after an accepted write opcode. A following write that is not preceded by a new write enable writes nothing.
- R9: A data byte whose address lies in the inclusive window prot_lo..prot_hi is dropped, but the address still advances. If prot_lo > prot_hi, the window is empty. This applies to bursts that start inside the window and to bursts that re-enter unprotected space after a wrap.
- R10: A read, fast read or write opcode received while busy is high is ignored. A data byte whose eighth bit arrives while busy is high is not written.
- R11: A data byte cut short by chip select rising is never written.
- R12: Each committed byte gives one single-cycle mem_we pulse carrying its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial read data |
| so_oe | output | 1 | Output enable for so; the pad is high impedance when low |
| busy | input | 1 | Store/recall cycle in progress |
| prot_lo | input | 15 | First address of the write-protected window |
| prot_hi | input | 15 | Last address of the write-protected window |
| mem_raddr | output | 15 | Array read address |
| mem_rdata | input | 8 | Array read data for mem_raddr |
| mem_we | output | 1 | Array write strobe, one cycle per byte |
| mem_waddr | output | 15 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
Two events can land in the same system-clock cycle: the rising SCK edge that completes a data byte, and chip select going high, which clears the write-enable latch and ends the frame. The bench raises chip select together with the final SCK rise. It then checks that exactly one write pulse appears with the right data, and that a write sent right after, with no new enable, changes nothing. The bench also sweeps a two-address protected window across a burst that wraps past 0x7FFF. The sweep covers cases where the window starts the burst, splits it, straddles the wrap (so it is empty), or sits just before the restart at zero. Every written and skipped byte is compared with an arithmetic model.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_FAST  = 8'h0B;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_RDATA,
        PH_WDATA,
        PH_IGNORE
    } phase_e;

    typedef enum logic [1:0] {
        KIND_READ,
        KIND_FAST,
        KIND_WRITE
    } kind_e;

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_hi,
    output logic si_s
);

    typedef struct packed {
        logic [STAGES-1:0] sck_p;
        logic [STAGES-1:0] cs_p;
        logic [STAGES-1:0] si_p;
        logic              sck_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.sck_p    = {q.sck_p[STAGES-2:0], sck};
        d.cs_p     = {q.cs_p[STAGES-2:0], cs_n};
        d.si_p     = {q.si_p[STAGES-2:0], si};
        d.sck_prev = q.sck_p[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sck_p    <= '0;
            q.cs_p     <= '1;
            q.si_p     <= '0;
            q.sck_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sck_rise = q.sck_p[STAGES-1] & ~q.sck_prev;
    assign sck_fall = ~q.sck_p[STAGES-1] & q.sck_prev;
    assign cs_hi    = q.cs_p[STAGES-1];
    assign si_s     = q.si_p[STAGES-1];

    a_r3_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_rise && sck_fall));

endmodule

// File: rtl/spi_wen_latch.sv
module spi_wen_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic wen
);

    logic wen_d, wen_q;

    always_comb begin
        wen_d = wen_q;
        if (set_req) wen_d = 1'b1;
        if (clr_req) wen_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wen_q <= 1'b0;
        else        wen_q <= wen_d;
    end

    assign wen = wen_q;

    // R8: a clear request always leaves the latch at zero
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !wen_q);

    a_r6_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && !clr_req) |=> wen_q);

endmodule

// File: rtl/spi_prot_window.sv
module spi_prot_window #(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] win_lo,
    input  logic [ADDR_W-1:0] win_hi,
    output logic              hit
);

    logic ordered;

    always_comb begin
        ordered = (win_lo <= win_hi);
        hit     = ordered && (addr >= win_lo) && (addr <= win_hi);
    end

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic              busy,
    input  logic [ADDR_W-1:0] prot_lo,
    input  logic [ADDR_W-1:0] prot_hi,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata
);

    localparam int ABITS = ((ADDR_W + 7) / 8) * 8;
    localparam int CNT_W = $clog2(ABITS) + 1;
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(7);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ABITS - 1);

    typedef struct packed {
        phase_e            ph;
        kind_e             kind;
        logic [CNT_W-1:0]  cnt;
        logic [ABITS-1:0]  sr;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        obit;
        logic              so;
        logic              so_oe;
        logic              wr_acc;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [7:0]        wdata;
    } ctl_t;

    ctl_t q, d;

    logic sck_rise, sck_fall, cs_hi, si_s;
    logic wen, wen_set, wen_clr, prot_hit;
    logic [7:0]        byte_in;
    logic [ADDR_W-1:0] addr_in;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .si       (si),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_hi    (cs_hi),
        .si_s     (si_s)
    );

    spi_wen_latch u_wen (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (wen_set),
        .clr_req (wen_clr),
        .wen     (wen)
    );

    spi_prot_window #(.ADDR_W(ADDR_W)) u_prot (
        .addr   (q.addr),
        .win_lo (prot_lo),
        .win_hi (prot_hi),
        .hit    (prot_hit)
    );

    always_comb begin
        d       = q;
        d.we    = 1'b0;
        wen_set = 1'b0;
        wen_clr = 1'b0;
        byte_in = {q.sr[6:0], si_s};
        addr_in = {q.sr[ADDR_W-2:0], si_s};

        // rising SCK: shift in and advance the frame
        if (sck_rise && q.ph != PH_IDLE) begin
            d.sr  = {q.sr[ABITS-2:0], si_s};
            d.cnt = q.cnt + 1'b1;
            case (q.ph)
                PH_CMD: begin
                    if (q.cnt == LAST_BIT) begin
                        d.cnt = '0;
                        d.ph  = PH_IGNORE;
                        if (byte_in == OPC_WREN) begin
                            wen_set = 1'b1;
                        end else if (byte_in == OPC_READ && !busy) begin
                            d.ph   = PH_ADDR;
                            d.kind = KIND_READ;
                        end else if (byte_in == OPC_FAST && !busy) begin
                            d.ph   = PH_ADDR;
                            d.kind = KIND_FAST;
                        end else if (byte_in == OPC_WRITE && wen && !busy) begin
                            d.ph     = PH_ADDR;
                            d.kind   = KIND_WRITE;
                            d.wr_acc = 1'b1;
                        end
                    end
                end
                PH_ADDR: begin
                    if (q.cnt == LAST_ADDR) begin
                        d.cnt  = '0;
                        d.addr = addr_in;
                        d.obit = '0;
                        case (q.kind)
                            KIND_FAST:  d.ph = PH_DUMMY;
                            KIND_WRITE: d.ph = PH_WDATA;
                            default:    d.ph = PH_RDATA;
                        endcase
                    end
                end
                PH_DUMMY: begin
                    if (q.cnt == LAST_BIT) begin
                        d.cnt = '0;
                        d.ph  = PH_RDATA;
                    end
                end
                PH_WDATA: begin
                    if (q.cnt == LAST_BIT) begin
                        d.cnt   = '0;
                        d.we    = !busy && !prot_hit;
                        d.waddr = q.addr;
                        d.wdata = byte_in;
                        d.addr  = q.addr + 1'b1;
                    end
                end
                default: ;
            endcase
        end

        // falling SCK: drive the next read bit, MSB first
        if (sck_fall && q.ph == PH_RDATA) begin
            d.so    = mem_rdata[3'd7 - q.obit];
            d.so_oe = 1'b1;
            d.obit  = q.obit + 1'b1;
            if (q.obit == 3'd7) d.addr = q.addr + 1'b1;
        end

        // chip select high ends the frame; a completing byte above is kept
        if (cs_hi) begin
            if (q.wr_acc) wen_clr = 1'b1;
            d.ph     = PH_IDLE;
            d.cnt    = '0;
            d.so_oe  = 1'b0;
            d.wr_acc = 1'b0;
        end else if (q.ph == PH_IDLE) begin
            d.ph  = PH_CMD;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph     <= PH_IDLE;
            q.kind   <= KIND_READ;
            q.cnt    <= '0;
            q.sr     <= '0;
            q.addr   <= '0;
            q.obit   <= '0;
            q.so     <= 1'b0;
            q.so_oe  <= 1'b0;
            q.wr_acc <= 1'b0;
            q.we     <= 1'b0;
            q.waddr  <= '0;
            q.wdata  <= '0;
        end else begin
            q <= d;
        end
    end

    assign so        = q.so;
    assign so_oe     = q.so_oe;
    assign mem_raddr = q.addr;
    assign mem_we    = q.we;
    assign mem_waddr = q.waddr;
    assign mem_wdata = q.wdata;

    // R3: output enable drops once chip select is seen high
    a_r3_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !so_oe);

    // R3: output enable only turns on at a falling SCK edge
    a_r3_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> $past(sck_fall));

    // R1: an unknown or refused opcode never drives the output
    a_r1_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_IGNORE) |-> !so_oe);

    // R6: a write strobe needs the enable latch set one cycle earlier
    a_r6_we_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(wen));

    // R9: nothing is written inside a non-empty protected window
    a_r9_no_prot_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !((prot_lo <= prot_hi) && (mem_waddr >= prot_lo) && (mem_waddr <= prot_hi)));

    // R10: no commit from a byte completed while busy
    a_r10_no_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(busy));

    // R12: write strobe is a single-cycle pulse
    a_r12_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

endmodule

// File: tb/spi_mem_slave_bench.sv
module spi_mem_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int AW         = 15;
    localparam int AMASK      = 32'h7FFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sck = 1'b0;
    logic          cs_n = 1'b1;
    logic          si = 1'b0;
    logic          busy = 1'b0;
    logic [AW-1:0] prot_lo = 15'd1;
    logic [AW-1:0] prot_hi = 15'd0;
    logic          so, so_oe, mem_we;
    logic [AW-1:0] mem_raddr, mem_waddr;
    logic [7:0]    mem_rdata = 8'h00;
    logic [7:0]    mem_wdata;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    bit wen_m = 1'b0;
    int we_count = 0;
    int oe_count = 0;

    logic [7:0] mem_model [int];
    logic [7:0] exp_model [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_mem_slave u_spi_mem_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (sck),
        .cs_n      (cs_n),
        .si        (si),
        .so        (so),
        .so_oe     (so_oe),
        .busy      (busy),
        .prot_lo   (prot_lo),
        .prot_hi   (prot_hi),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata)
    );

    function automatic logic [7:0] bg(input int a);
        return 8'((a * 7) + (a >> 8) + 8'h35);
    endfunction

    function automatic logic [7:0] exp_at(input int a);
        if (exp_model.exists(a)) return exp_model[a];
        return bg(a);
    endfunction

    function automatic bit in_win(input int a);
        return (prot_lo <= prot_hi) && (a >= int'(prot_lo)) && (a <= int'(prot_hi));
    endfunction

    // behavioural array
    always @(posedge clk) begin
        if (mem_we) begin
            mem_model[int'(mem_waddr)] = mem_wdata;
            we_count = we_count + 1;
        end
    end

    always @(negedge clk) begin
        mem_rdata <= mem_model.exists(int'(mem_raddr)) ? mem_model[int'(mem_raddr)]
                                                       : bg(int'(mem_raddr));
        if (so_oe) oe_count = oe_count + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            si = tx[i];
            wait_half();
            rx[i] = so_oe ? so : 1'bx;
            sck = 1'b1;
            wait_half();
            sck = 1'b0;
        end
    endtask

    task automatic frame_open();
        cs_n = 1'b0;
        wait_half();
    endtask

    task automatic frame_close();
        wait_half();
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic send_wren();
        logic [7:0] r;
        frame_open();
        xfer(8'h06, r);
        frame_close();
        wen_m = 1'b1;
    endtask

    // write burst; busy rises at byte index busy_from (negative: never)
    task automatic spi_write(input int a, input int n, input int seed, input int busy_from,
                             input string req);
        logic [7:0] r, dv;
        int  w0, expw, ad;
        bit  acc;
        w0   = we_count;
        expw = 0;
        acc  = wen_m && !busy;
        frame_open();
        xfer(8'h02, r);
        xfer(8'((a >> 8) & 255), r);
        xfer(8'(a & 255), r);
        for (int i = 0; i < n; i++) begin
            if (i == busy_from) busy = 1'b1;
            dv = 8'(seed + i * 29);
            xfer(dv, r);
            ad = (a + i) & AMASK;
            if (acc && !busy && !in_win(ad)) begin
                exp_model[ad] = dv;
                expw = expw + 1;
            end
        end
        frame_close();
        busy = 1'b0;
        if (acc) wen_m = 1'b0;
        check(we_count - w0 == expw, req, we_count - w0, expw);
    endtask

    task automatic spi_read(input int a, input int n, input bit fast, input string req);
        logic [7:0] r;
        int ad;
        frame_open();
        xfer(fast ? 8'h0B : 8'h03, r);
        xfer(8'((a >> 8) & 255), r);
        xfer(8'(a & 255), r);
        if (fast) xfer(8'hC3, r);
        for (int i = 0; i < n; i++) begin
            xfer(8'h5A, r);
            ad = (a + i) & AMASK;
            check(r === exp_at(ad), req, int'(r), int'(exp_at(ad)));
        end
        frame_close();
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, dv;
        int w0, o0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state (R3, R12)
        check(so_oe == 1'b0, "R3 reset oe", int'(so_oe), 0);
        check(mem_we == 1'b0, "R12 reset we", int'(mem_we), 0);

        // background content through READ and FAST_READ (R3, R5)
        spi_read(16'h0123, 3, 1'b0, "R3");
        spi_read(16'h0456, 3, 1'b1, "R5");

        // write without enable is ignored (R6)
        spi_write(16'h0100, 2, 8'h11, -1, "R6");
        spi_read(16'h0100, 2, 1'b0, "R6");

        // burst write across the top of the array (R7), read back across wrap (R4, R5)
        send_wren();
        spi_write(16'h7FFD, 6, 8'h40, -1, "R7");
        spi_read(16'h7FFB, 9, 1'b0, "R4");
        spi_read(16'h7FFE, 4, 1'b1, "R5");

        // enable cleared after the write frame (R8)
        spi_write(16'h0200, 2, 8'h77, -1, "R8");
        spi_read(16'h0200, 2, 1'b0, "R8");

        // bit 15 of the address ignored (R2)
        send_wren();
        spi_write(16'h8005, 2, 8'h9C, -1, "R2");
        spi_read(16'h0005, 2, 1'b0, "R2");
        spi_read(16'hFFFF, 2, 1'b1, "R2");

        // unknown opcode: no output, no write (R1)
        w0 = we_count; o0 = oe_count;
        frame_open();
        xfer(8'hA5, r); xfer(8'h00, r); xfer(8'h10, r); xfer(8'h55, r); xfer(8'h55, r);
        frame_close();
        check(oe_count == o0, "R1 oe", oe_count - o0, 0);
        check(we_count == w0, "R1 we", we_count - w0, 0);

        // busy refuses READ and WRITE (R10)
        busy = 1'b1;
        o0 = oe_count;
        frame_open();
        xfer(8'h03, r); xfer(8'h00, r); xfer(8'h20, r); xfer(8'h00, r);
        frame_close();
        busy = 1'b0;
        check(oe_count == o0, "R10 read", oe_count - o0, 0);
        send_wren();
        busy = 1'b1;
        spi_write(16'h0300, 2, 8'h21, -1, "R10");
        wen_m = 1'b1;
        // busy rising mid-burst suppresses later bytes (R10)
        spi_write(16'h0310, 3, 8'h31, 1, "R10");
        spi_read(16'h0300, 2, 1'b0, "R10");
        spi_read(16'h0310, 3, 1'b0, "R10");

        // partial byte discarded (R11)
        send_wren();
        w0 = we_count;
        frame_open();
        xfer(8'h02, r); xfer(8'h04, r); xfer(8'h00, r);
        xfer(8'hE1, r);
        for (int i = 7; i >= 4; i--) begin
            si = 1'b1; wait_half(); sck = 1'b1; wait_half(); sck = 1'b0;
        end
        frame_close();
        exp_model[16'h0400] = 8'hE1;
        wen_m = 1'b0;
        check(we_count - w0 == 1, "R11", we_count - w0, 1);
        spi_read(16'h0400, 2, 1'b0, "R11");

        // chip select rising in the same cycle as the last data bit (R7, R8)
        send_wren();
        w0 = we_count;
        dv = 8'h6B;
        frame_open();
        xfer(8'h02, r); xfer(8'h05, r); xfer(8'h55, r);
        for (int i = 7; i >= 1; i--) begin
            si = dv[i]; wait_half(); sck = 1'b1; wait_half(); sck = 1'b0;
        end
        si = dv[0];
        wait_half();
        sck = 1'b1;
        cs_n = 1'b1;
        wait_half();
        sck = 1'b0;
        repeat (4 * HALF) @(negedge clk);
        exp_model[16'h0555] = dv;
        wen_m = 1'b0;
        check(we_count - w0 == 1, "R7 edge commit", we_count - w0, 1);
        spi_write(16'h0555, 1, 8'h01, -1, "R8 edge");
        spi_read(16'h0555, 1, 1'b1, "R7");

        // protected window swept across a wrapping burst (R9)
        for (int k = 0; k < 8; k++) begin
            prot_lo = AW'((32'h7FFC + k) & AMASK);
            prot_hi = AW'((32'h7FFC + k + 1) & AMASK);
            repeat (2) @(negedge clk);
            send_wren();
            spi_write(16'h7FFC, 8, 8'h80 + k * 13, -1, "R9");
            spi_read(16'h7FFB, 10, k[0], "R9");
        end
        prot_lo = 15'd1;
        prot_hi = 15'd0;

        // long read burst over the wrap point (R4)
        spi_read(16'h7FF0, 40, 1'b0, "R4");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule